// File: doc/BRIEF.md
# Coprocessor Memory Window Transfer Engine

This block gives a host processor a narrow window into the memory spaces of an attached coprocessor. The host programs an address register, an upper address byte and a configuration word over a small register bus. It then moves 16-bit words through one data port. A 3-bit region field tags every access. The tag selects data memory, the register space, program memory or an external bus. The coprocessor receives each access on a generic request port that carries the address, the write data and the region tag.

Host writes to the data port go straight out as single write requests. Reads are prefetched. A burst command loads a remaining-word count from a 2-bit length code, which can also select an unbounded stream. The engine then keeps a 16-entry read FIFO topped up while words remain. Each host read of the data port pops the oldest word. A cancel command drops the stream and empties the FIFO. The address can step by one after every access. The step wraps inside the 16-bit address register and never carries into the upper byte.

Top module: `cpWindowEngine`

## Requirements
- R1: Config bits 14:12 give the region. Code 0 is data memory, 1 is register space, 5 is program memory and 7 is the external bus. The region appears on `memRegion`. For codes 0, 5 and 7, `memAddr` is the upper byte (register 4) over the 16-bit address (register 1). For code 1, `memAddr` carries only the low 11 address bits and is zero above them.
- R2: Region codes 2, 3, 4 and 6 never assert `memReq`. A data port write in such a region raises no interrupt. A read burst in such a region delivers 0-valued words and leaves the address unchanged.
- R3: When config bit 1 is set, the address register steps by one after every issued access. It wraps from 0xFFFF to 0x0000, and the upper byte is unchanged. When bit 1 is clear, the address is unchanged.
- R4: A write to register 3 stores the burst code from data bits 3:2. Codes 0, 1 and 2 fetch 1, 8 and 16 words. Code 3 fetches without limit.
- R5: A write to register 3 with bit 0 set and bit 1 clear starts a burst. `hostIrq` pulses in the following cycle.
- R6: The read FIFO never holds more than 16 words. A read request is issued only while the FIFO plus the read in flight leave room.
- R7: A host read of register 0 returns the oldest FIFO word and pops it. Words come out in address order. With the FIFO empty, the read returns 0. Popped space is refilled while burst words remain.
- R8: A write to register 3 with bit 1 set cancels. The FIFO is empty in the next cycle, and no further read requests are issued.
- R9: A host write to register 0 in a valid region drives exactly one write request in that cycle, with `memWe` high and the data on `memWdata`. `hostIrq` pulses in the following cycle.
- R10: With code 3, fetching never stops on a count. After the host drains any number of words, the FIFO refills to 16.
- R11: After reset, the address, upper byte and config read as 0, the status reads 0, the data port reads 0 and `memReq` is low.
- R12: Register 3 reads back the burst code in bits 3:2, FIFO full in bit 5 and FIFO non-empty in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Register bus select |
| hostWr | input | 1 | Register write strobe |
| hostRd | input | 1 | Register read strobe (pops on register 0) |
| hostAddr | input | 3 | Register index |
| hostWdata | input | 16 | Register write data |
| hostRdata | output | 16 | Register read data, combinational |
| hostIrq | output | 1 | One-cycle interrupt pulse |
| memReq | output | 1 | Coprocessor access request |
| memWe | output | 1 | Access is a write |
| memRegion | output | 3 | Region tag of the access |
| memAddr | output | 24 | Access address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid one cycle after a read request |

## Verification
The bench walks a table of region, upper byte and address values. It catches a design that leaks the upper byte into register-space addresses, or that issues requests for unused region codes. It steps the address across 0xFFFF to expose a carry into the upper byte. It runs each burst length and counts the words delivered. A wrong length decode shows up as an extra or missing word, or as a nonzero read after the burst should be done. In the unbounded stream it drains more than one FIFO's worth and checks the order and the refill to full. A cancel that left stale words, or kept fetching, shows up in the status, in the data port and in an address that keeps moving.

// File: rtl/cwe_pkg.sv
package cwe_pkg;

  localparam int HOST_AW = 3;
  localparam logic [HOST_AW-1:0] REG_DATA  = 3'd0;
  localparam logic [HOST_AW-1:0] REG_ADDR  = 3'd1;
  localparam logic [HOST_AW-1:0] REG_CFG   = 3'd2;
  localparam logic [HOST_AW-1:0] REG_BURST = 3'd3;
  localparam logic [HOST_AW-1:0] REG_HIGH  = 3'd4;

  typedef enum logic [2:0] {
    RGN_DATA = 3'd0,
    RGN_REGS = 3'd1,
    RGN_PROG = 3'd5,
    RGN_EXT  = 3'd7
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrWr;
    logic cfgWr;
    logic highWr;
    logic memWrite;  // host write to data port, valid region
    logic fetch;     // prefetch slot taken this cycle
    logic pop;       // host read of data port
    logic flush;     // cancel
  } cweStrobe_t;

  function automatic logic regionValid(input logic [2:0] rgn);
    return (rgn == RGN_DATA) || (rgn == RGN_REGS) ||
           (rgn == RGN_PROG) || (rgn == RGN_EXT);
  endfunction

endpackage

// File: rtl/cwe_fifo.sv
module cwe_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic [LVLW-1:0]  level
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTRW-1:0]  wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPop  = pop && (level != '0);
  assign doPush = push && ((level != LVLW'(DEPTH)) || doPop);
  assign head   = (level != '0) ? store[rdPtr] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (doPush && !flush && (wrPtr == PTRW'(i))) store[i] <= pushData;
      end
    end
  endgenerate

endmodule

// File: rtl/cwe_ctrl.sv
module cwe_ctrl
  import cwe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [3:0]         hostCmd,
  input  logic [2:0]         cfgRegion,
  input  logic [LVLW-1:0]    fifoLevel,
  input  logic               readInFlight,
  output cweStrobe_t         strobe,
  output logic [1:0]         burstCode,
  output logic               hostIrq
);

  logic            dataSel, burstWr, startCmd, cancelCmd, wantMore, hasRoom;
  logic [LVLW-1:0] remaining;
  logic            unbounded;
  logic [LVLW:0]   committed;

  assign dataSel   = hostSel && (hostAddr == REG_DATA);
  assign burstWr   = hostSel && hostWr && (hostAddr == REG_BURST);
  assign cancelCmd = burstWr && hostCmd[1];
  assign startCmd  = burstWr && hostCmd[0] && !hostCmd[1];

  assign committed = {1'b0, fifoLevel} + (LVLW+1)'(readInFlight);
  assign hasRoom   = committed < (LVLW+1)'(DEPTH);
  assign wantMore  = unbounded || (remaining != '0);

  always_comb begin
    strobe          = '0;
    strobe.addrWr   = hostSel && hostWr && (hostAddr == REG_ADDR);
    strobe.cfgWr    = hostSel && hostWr && (hostAddr == REG_CFG);
    strobe.highWr   = hostSel && hostWr && (hostAddr == REG_HIGH);
    strobe.memWrite = dataSel && hostWr && regionValid(cfgRegion);
    strobe.pop      = dataSel && hostRd && !hostWr;
    strobe.flush    = cancelCmd;
    strobe.fetch    = wantMore && hasRoom && !strobe.memWrite &&
                      !startCmd && !cancelCmd;
  end

  function automatic logic [LVLW-1:0] burstLen(input logic [1:0] code);
    case (code)
      2'd0:    return LVLW'(1);
      2'd1:    return LVLW'(8);
      default: return LVLW'(DEPTH);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      unbounded <= 1'b0;
      burstCode <= '0;
      hostIrq   <= 1'b0;
    end else begin
      hostIrq <= startCmd || strobe.memWrite;
      if (burstWr) burstCode <= hostCmd[3:2];
      if (cancelCmd) begin
        remaining <= '0;
        unbounded <= 1'b0;
      end else if (startCmd) begin
        unbounded <= (hostCmd[3:2] == 2'd3);
        remaining <= (hostCmd[3:2] == 2'd3) ? '0 : burstLen(hostCmd[3:2]);
      end else if (strobe.fetch && !unbounded) begin
        remaining <= remaining - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cwe_datapath.sv
module cwe_datapath
  import cwe_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATAW   = 16,
  parameter int HIGHW   = 8,
  parameter int REGSW   = 11,
  localparam int MEMAW  = HIGHW + DATAW,
  localparam int LVLW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cweStrobe_t         strobe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATAW-1:0]   hostWdata,
  input  logic [1:0]         burstCode,
  output logic [DATAW-1:0]   hostRdata,
  output logic [2:0]         cfgRegion,
  output logic [LVLW-1:0]    fifoLevel,
  output logic               readInFlight,
  output logic               memReq,
  output logic               memWe,
  output logic [2:0]         memRegion,
  output logic [MEMAW-1:0]   memAddr,
  output logic [DATAW-1:0]   memWdata,
  input  logic [DATAW-1:0]   memRdata
);

  logic [DATAW-1:0] winAddr;
  logic [HIGHW-1:0] highAddr;
  logic             autoStep;
  logic             pendingZero;
  logic             inRange;
  logic [DATAW-1:0] fifoHead;
  logic [DATAW-1:0] statusWord;
  logic             fifoPush;
  logic [DATAW-1:0] fifoIn;

  assign inRange   = regionValid(cfgRegion);
  assign memReq    = strobe.memWrite || (strobe.fetch && inRange);
  assign memWe     = strobe.memWrite;
  assign memRegion = cfgRegion;
  assign memWdata  = hostWdata;
  assign memAddr   = (cfgRegion == RGN_REGS)
                   ? MEMAW'(winAddr[REGSW-1:0])
                   : {highAddr, winAddr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winAddr   <= '0;
      highAddr  <= '0;
      cfgRegion <= '0;
      autoStep  <= 1'b0;
    end else begin
      if (strobe.cfgWr) begin
        cfgRegion <= hostWdata[14:12];
        autoStep  <= hostWdata[1];
      end
      if (strobe.highWr) highAddr <= hostWdata[HIGHW-1:0];
      if (strobe.addrWr)            winAddr <= hostWdata;
      else if (memReq && autoStep)  winAddr <= winAddr + 1'b1;
    end
  end

  // one-cycle read return; out-of-range slots deliver zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readInFlight <= 1'b0;
      pendingZero  <= 1'b0;
    end else begin
      readInFlight <= strobe.fetch && !strobe.flush;
      pendingZero  <= !inRange;
    end
  end

  assign fifoPush = readInFlight && !strobe.flush;
  assign fifoIn   = pendingZero ? '0 : memRdata;

  cwe_fifo #(.WIDTH(DATAW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (fifoIn),
    .pop      (strobe.pop),
    .flush    (strobe.flush),
    .head     (fifoHead),
    .level    (fifoLevel)
  );

  always_comb begin
    statusWord      = '0;
    statusWord[3:2] = burstCode;
    statusWord[5]   = (fifoLevel == LVLW'(DEPTH));
    statusWord[6]   = (fifoLevel != '0);
  end

  always_comb begin
    case (hostAddr)
      REG_DATA:  hostRdata = fifoHead;
      REG_ADDR:  hostRdata = winAddr;
      REG_CFG:   hostRdata = DATAW'({1'b0, cfgRegion, 10'd0, autoStep, 1'b0});
      REG_BURST: hostRdata = statusWord;
      REG_HIGH:  hostRdata = DATAW'(highAddr);
      default:   hostRdata = '0;
    endcase
  end

endmodule

// File: rtl/cpWindowEngine.sv
module cpWindowEngine
  import cwe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATAW  = 16,
  parameter int HIGHW  = 8,
  localparam int MEMAW = HIGHW + DATAW,
  localparam int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostSel,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [2:0]       hostAddr,
  input  logic [DATAW-1:0] hostWdata,
  output logic [DATAW-1:0] hostRdata,
  output logic             hostIrq,
  output logic             memReq,
  output logic             memWe,
  output logic [2:0]       memRegion,
  output logic [MEMAW-1:0] memAddr,
  output logic [DATAW-1:0] memWdata,
  input  logic [DATAW-1:0] memRdata
);

  cweStrobe_t      strobe;
  logic [1:0]      burstCode;
  logic [2:0]      cfgRegion;
  logic [LVLW-1:0] fifoLevel;
  logic            readInFlight;

  cwe_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostSel      (hostSel),
    .hostWr       (hostWr),
    .hostRd       (hostRd),
    .hostAddr     (hostAddr),
    .hostCmd      (hostWdata[3:0]),
    .cfgRegion    (cfgRegion),
    .fifoLevel    (fifoLevel),
    .readInFlight (readInFlight),
    .strobe       (strobe),
    .burstCode    (burstCode),
    .hostIrq      (hostIrq)
  );

  cwe_datapath #(.DEPTH(DEPTH), .DATAW(DATAW), .HIGHW(HIGHW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .hostAddr     (hostAddr),
    .hostWdata    (hostWdata),
    .burstCode    (burstCode),
    .hostRdata    (hostRdata),
    .cfgRegion    (cfgRegion),
    .fifoLevel    (fifoLevel),
    .readInFlight (readInFlight),
    .memReq       (memReq),
    .memWe        (memWe),
    .memRegion    (memRegion),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memRdata     (memRdata)
  );

endmodule

// File: rtl/cpWindowEngine_checker.sv
module cpWindowEngine_checker #(
  parameter int DEPTH = 16,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            hostSel,
  input logic            hostWr,
  input logic [2:0]      hostAddr,
  input logic [15:0]     hostWdata,
  input logic            hostIrq,
  input logic            memReq,
  input logic            memWe,
  input logic [2:0]      memRegion,
  input logic [23:0]     memAddr,
  input logic [LVLW-1:0] fifoLevel
);

  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVLW'(DEPTH));

  assert_read_has_room_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (fifoLevel < LVLW'(DEPTH)));

  assert_valid_region_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memRegion == 3'd0 || memRegion == 3'd1 ||
                memRegion == 3'd5 || memRegion == 3'd7));

  assert_regs_addr_narrow_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRegion == 3'd1) |-> (memAddr[23:11] == '0));

  assert_cancel_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr == 3'd3 && hostWdata[1]) |=> (fifoLevel == '0));

  assert_write_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> hostIrq);

endmodule

bind cpWindowEngine cpWindowEngine_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostSel   (hostSel),
  .hostWr    (hostWr),
  .hostAddr  (hostAddr),
  .hostWdata (hostWdata),
  .hostIrq   (hostIrq),
  .memReq    (memReq),
  .memWe     (memWe),
  .memRegion (memRegion),
  .memAddr   (memAddr),
  .fifoLevel (fifoLevel)
);

// File: tb/test_cpWindowEngine.sv
module test_cpWindowEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostIrq, memReq, memWe;
  logic [2:0]  memRegion;
  logic [23:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int reqSeen;

  always #10 clk = ~clk;

  cpWindowEngine i_cpWindowEngine (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostIrq(hostIrq), .memReq(memReq), .memWe(memWe), .memRegion(memRegion),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // memory model: read word is a function of address and region
  function automatic logic [15:0] memWord(input logic [2:0] rgn, input logic [23:0] a);
    return a[15:0] ^ {rgn, 13'd0} ^ {8'd0, a[23:16]};
  endfunction

  always @(posedge clk) begin
    if (memReq && !memWe) memRdata <= memWord(memRegion, memAddr);
    if (memReq) reqSeen <= reqSeen + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostRd = 1'b1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostSel = 1'b0; hostRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // region, high byte, address, expected memAddr, expected request
  localparam int NVEC = 6;
  localparam logic [51:0] VEC [NVEC] = '{
    {3'd0, 8'h12, 16'h3456, 24'h123456, 1'b1},
    {3'd1, 8'h12, 16'hFFFF, 24'h0007FF, 1'b1},
    {3'd5, 8'hA0, 16'h0001, 24'hA00001, 1'b1},
    {3'd7, 8'hFF, 16'h8000, 24'hFF8000, 1'b1},
    {3'd2, 8'h01, 16'h0101, 24'h000000, 1'b0},
    {3'd6, 8'h01, 16'h0202, 24'h000000, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    reqSeen = 0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R11 reset state
    check("R11 memReq", {31'd0, memReq}, 32'd0);
    regRead(3'd1, rd); check("R11 addr", {16'd0, rd}, 32'd0);
    regRead(3'd2, rd); check("R11 cfg", {16'd0, rd}, 32'd0);
    regRead(3'd3, rd); check("R11 status", {16'd0, rd}, 32'd0);
    regRead(3'd4, rd); check("R11 high", {16'd0, rd}, 32'd0);
    regRead(3'd0, rd); check("R7 empty read", {16'd0, rd}, 32'd0);

    // R1 R2 R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v;
      v = VEC[i];
      regWrite(3'd2, {1'b0, v[51:49], 12'd0});
      regWrite(3'd4, {8'd0, v[48:41]});
      regWrite(3'd1, v[40:25]);
      @(negedge clk);
      hostSel = 1'b1; hostWr = 1'b1; hostAddr = 3'd0; hostWdata = 16'hC0DE ^ 16'(i);
      #1;
      check("R2 R9 memReq", {31'd0, memReq}, {31'd0, v[0]});
      if (v[0]) begin
        check("R1 memAddr", {8'd0, memAddr}, {8'd0, v[24:1]});
        check("R1 memRegion", {29'd0, memRegion}, {29'd0, v[51:49]});
        check("R9 memWe", {31'd0, memWe}, 32'd1);
        check("R9 memWdata", {16'd0, memWdata}, {16'd0, 16'hC0DE ^ 16'(i)});
      end
      @(negedge clk);
      hostSel = 1'b0; hostWr = 1'b0;
      check("R2 R9 irq", {31'd0, hostIrq}, {31'd0, v[0]});
    end

    // R3 address step and wrap
    regWrite(3'd2, 16'h0002);
    regWrite(3'd4, 16'h0033);
    regWrite(3'd1, 16'hFFFF);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = 3'd0; hostWdata = 16'h1111;
    #1 check("R3 first addr", {8'd0, memAddr}, 32'h0033FFFF);
    @(negedge clk);
    #1 check("R3 wrapped addr", {8'd0, memAddr}, 32'h00330000);
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
    regRead(3'd1, rd); check("R3 addr reg", {16'd0, rd}, 32'h0001);
    regRead(3'd4, rd); check("R3 high kept", {16'd0, rd}, 32'h0033);
    regWrite(3'd2, 16'h0000);
    regWrite(3'd0, 16'h2222);
    regRead(3'd1, rd); check("R3 no step", {16'd0, rd}, 32'h0001);

    // R4 R5 R7 code 0: one word
    regWrite(3'd2, 16'h0002);
    regWrite(3'd4, 16'h0000);
    regWrite(3'd1, 16'h0100);
    regWrite(3'd3, 16'h0001);
    check("R5 start irq", {31'd0, hostIrq}, 32'd1);
    idle(10);
    regRead(3'd3, rd); check("R12 status one", {16'd0, rd}, 32'h0040);
    regRead(3'd0, rd); check("R4 code0 word", {16'd0, rd}, 32'h0100);
    regRead(3'd0, rd); check("R4 R7 code0 done", {16'd0, rd}, 32'h0000);
    regRead(3'd1, rd); check("R3 R4 addr after one", {16'd0, rd}, 32'h0101);

    // R4 code 1: eight words
    regWrite(3'd1, 16'h0200);
    regWrite(3'd3, 16'h0005);
    idle(20);
    regRead(3'd3, rd); check("R12 status eight", {16'd0, rd}, 32'h0044);
    for (int k = 0; k < 8; k++) begin
      regRead(3'd0, rd); check("R4 R7 code1 word", {16'd0, rd}, 32'h0200 + 32'(k));
    end
    regRead(3'd0, rd); check("R4 code1 done", {16'd0, rd}, 32'h0000);

    // R4 R6 code 2: sixteen words, FIFO full
    regWrite(3'd1, 16'h0300);
    regWrite(3'd3, 16'h0009);
    idle(30);
    regRead(3'd3, rd); check("R6 R12 full", {16'd0, rd}, 32'h0068);
    for (int k = 0; k < 16; k++) begin
      regRead(3'd0, rd); check("R4 code2 word", {16'd0, rd}, 32'h0300 + 32'(k));
    end
    regRead(3'd1, rd); check("R4 code2 addr", {16'd0, rd}, 32'h0310);

    // R10 R6 unbounded
    regWrite(3'd1, 16'h0400);
    regWrite(3'd3, 16'h000D);
    idle(30);
    regRead(3'd1, rd); check("R6 stall at full", {16'd0, rd}, 32'h0410);
    for (int k = 0; k < 20; k++) begin
      regRead(3'd0, rd); check("R10 stream word", {16'd0, rd}, 32'h0400 + 32'(k));
      idle(2);
    end
    idle(10);
    regRead(3'd3, rd); check("R10 refilled", {16'd0, rd & 16'h0020}, 32'h0020);
    regRead(3'd1, rd); check("R10 addr", {16'd0, rd}, 32'h0424);

    // R8 cancel
    regWrite(3'd3, 16'h000E);
    regRead(3'd3, rd); check("R8 status empty", {16'd0, rd & 16'h0060}, 32'h0000);
    regRead(3'd0, rd); check("R8 data zero", {16'd0, rd}, 32'h0000);
    idle(10);
    regRead(3'd1, rd); check("R8 no more fetch", {16'd0, rd}, 32'h0424);

    // R1 register-space read burst, no step
    regWrite(3'd2, 16'h1000);
    regWrite(3'd4, 16'h00AB);
    regWrite(3'd1, 16'h0FFF);
    regWrite(3'd3, 16'h0005);
    idle(20);
    regRead(3'd0, rd); check("R1 regs read", {16'd0, rd}, {16'd0, memWord(3'd1, 24'h0007FF)});
    regWrite(3'd3, 16'h0002);
    regRead(3'd3, rd); check("R8 cancel mid", {16'd0, rd & 16'h0060}, 32'h0000);

    // R2 invalid region read burst
    regWrite(3'd2, 16'h3002);
    regWrite(3'd1, 16'h0500);
    @(negedge clk);
    reqSeen = 0;
    regWrite(3'd3, 16'h0005);
    idle(20);
    check("R2 no requests", 32'(reqSeen), 32'd0);
    regRead(3'd3, rd); check("R2 zeros queued", {16'd0, rd & 16'h0040}, 32'h0040);
    regRead(3'd0, rd); check("R2 zero word", {16'd0, rd}, 32'h0000);
    regRead(3'd1, rd); check("R2 addr kept", {16'd0, rd}, 32'h0500);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule